// File: doc/BRIEF.md
# Pin controller with edge-event interrupt

This block controls 32 general-purpose pins through a small word-addressed register bus. Each pin can be set to drive or to listen. When a driving pin is switched to open-drain, it is only pulled low. In that mode a written 1 lets the pad float instead of driving it high. Each pad input passes through two synchronising flops. The block then compares the result with its own value from the cycle before, to find rising and falling transitions. A transition of the kind selected for the pin sets a sticky event bit. The events are gated by a per-pin enable mask, and any enabled event drives the single interrupt line.

An elaboration parameter chooses one of two sense schemes. In the narrow scheme, one control bit per pin selects either falling transitions only or both directions. In the wide scheme, each pin has a two-bit sense code, and the codes are split across two control words. The wide scheme also makes the last four pins listen-only. Software finds the interrupting pins by reading the event word. It acknowledges them by writing ones back to that word.

The sense code is a small enumeration with four named values. SNS_BOTH (00) reacts to any transition. SNS_RISE (01) reacts to low-to-high only. SNS_FALL (10) reacts to high-to-low only. SNS_OFF (11) never reacts. Each pin's event logic decodes its code and moves between two conditions: idle, and event pending. It goes from idle to pending on a matching transition. It goes back from pending to idle only on an acknowledge write with no new transition in the same cycle.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, every pad output enable is 0 and the interrupt is low.
- R2: Pin n is bit 31-n in every per-pin word. The word offsets are 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C events, 0x10 mask, 0x14 sense control A and 0x18 sense control B. Any other address, including an unaligned one, reads 0.
- R3: A direction bit of 1 makes the pin drive. Without open-drain, pad_oe[n] equals the pin's direction bit and pad_out[n] equals its data bit.
- R4: With the open-drain bit set, a driving pin enables its pad only while its data bit is 0. A data bit of 1 releases the pad.
- R5: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. If a selected transition arrives in the same cycle as the clear, the bit stays set. With no write to the event word, event bits never clear.
- R6: A pad transition is seen on the synchronised level two clocks after it is applied. The event bit sets on the third clock. This happens for every pin, whatever its direction.
- R7: The interrupt is high exactly when some event bit and its mask bit are both 1.
- R8: In the narrow scheme, control A bit 31-n = 1 selects falling transitions only for pin n, and 0 selects both. Control B reads 0 and ignores writes.
- R9: In the wide scheme, pins 0..15 take their code from control A and pins 16..31 from control B. The field sits at bit offset (15 - n mod 16)*2. The codes are 00 both, 01 rising, 10 falling and 11 none.
- R10: In the wide scheme, pins 28..31 cannot drive: their direction bits (bits 3..0) read 0 and ignore writes.
- R11: A data-word read returns the synchronised pad level for listening pins and the written data bit for driving pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pad input levels, index = pin number |
| pad_out | output | 32 | Pad output values, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the write strobe and address are stable around the clock edge. They also assume that pad inputs may change at any time, because the synchroniser absorbs that. The event checks assume that the only way an event bit clears is a write of ones to the event word. The stimulus drives the bus and the pads only at falling clock edges. Apart from one directed test, it keeps each pad change apart from bus traffic for four clocks, so the expected event set can be computed from the old and new levels. The one directed test lines a write-one clear up with the cycle in which a transition is detected.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Per-pin sense code: which transitions create an event
    typedef enum logic [1:0] {
        SNS_BOTH = 2'b00,
        SNS_RISE = 2'b01,
        SNS_FALL = 2'b10,
        SNS_OFF  = 2'b11
    } sense_e;

    // Word indices of the register file (byte offset = 4 * index)
    localparam int unsigned IX_DIR = 0;
    localparam int unsigned IX_ODE = 1;
    localparam int unsigned IX_DAT = 2;
    localparam int unsigned IX_EVT = 3;
    localparam int unsigned IX_MSK = 4;
    localparam int unsigned IX_CT1 = 5;
    localparam int unsigned IX_CT2 = 6;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] lvl,
    output logic [DW-1:0] lvl_d
);

    logic [DW-1:0] meta;

    // two-flop synchroniser followed by a one-cycle history flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta  <= '0;
            lvl   <= '0;
            lvl_d <= '0;
        end else begin
            meta  <= pin_in;
            lvl   <= meta;
            lvl_d <= lvl;
        end
    end

endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense
    import gpio_edge_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]      lvl,
    input  logic [DW-1:0]      lvl_d,
    input  logic [DW-1:0][1:0] code,
    output logic [DW-1:0]      hit
);

    for (genvar n = 0; n < DW; n++) begin : g_pin
        logic rise;
        logic fall;
        logic h;

        assign rise = lvl[n] & ~lvl_d[n];
        assign fall = ~lvl[n] & lvl_d[n];

        always_comb begin
            unique case (sense_e'(code[n]))
                SNS_BOTH: h = rise | fall;
                SNS_RISE: h = rise;
                SNS_FALL: h = fall;
                SNS_OFF:  h = 1'b0;
            endcase
        end

        assign hit[n] = h;
    end

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter bit TWO_BIT = 1'b0,
    parameter int RO_PINS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [DW-1:0]      lvl,
    input  logic [DW-1:0]      hit,
    output logic [DW-1:0]      dir,
    output logic [DW-1:0]      od,
    output logic [DW-1:0]      dat,
    output logic [DW-1:0]      evt,
    output logic [DW-1:0]      msk,
    output logic [DW-1:0][1:0] code
);

    localparam int WW   = AW - 2;
    localparam int HALF = DW / 2;
    // pins that may drive (pin-indexed); the wide scheme locks the top pins
    localparam logic [DW-1:0] DIR_KEEP = TWO_BIT ? ({DW{1'b1}} >> RO_PINS) : {DW{1'b1}};

    // register bit 31-n <-> pin n
    function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
        return r;
    endfunction

    logic [WW-1:0] word;
    logic          aligned;
    logic [DW-1:0] wd;
    logic          w_dir, w_ode, w_dat, w_evt, w_msk, w_ct1, w_ct2;
    logic [DW-1:0] ctl1_q;
    logic [DW-1:0] ctl2_q;

    assign word    = bus_addr[AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wd      = flip(bus_wdata);

    assign w_dir = bus_we && aligned && (word == WW'(IX_DIR));
    assign w_ode = bus_we && aligned && (word == WW'(IX_ODE));
    assign w_dat = bus_we && aligned && (word == WW'(IX_DAT));
    assign w_evt = bus_we && aligned && (word == WW'(IX_EVT));
    assign w_msk = bus_we && aligned && (word == WW'(IX_MSK));
    assign w_ct1 = bus_we && aligned && (word == WW'(IX_CT1));
    assign w_ct2 = bus_we && aligned && (word == WW'(IX_CT2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir    <= '0;
            od     <= '0;
            dat    <= '0;
            evt    <= '0;
            msk    <= '0;
            ctl1_q <= '0;
        end else begin
            if (w_dir) dir    <= wd & DIR_KEEP;
            if (w_ode) od     <= wd;
            if (w_dat) dat    <= wd;
            if (w_msk) msk    <= wd;
            if (w_ct1) ctl1_q <= bus_wdata;
            // a transition in the clearing cycle wins over the clear
            evt <= (evt & ~(w_evt ? wd : '0)) | hit;
        end
    end

    if (TWO_BIT) begin : g_ctl2
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ctl2_q <= '0;
            else if (w_ct2) ctl2_q <= bus_wdata;
        end
    end else begin : g_no_ctl2
        assign ctl2_q = '0;
    end

    // per-pin sense code from the control words
    for (genvar n = 0; n < DW; n++) begin : g_code
        if (TWO_BIT) begin : g_wide
            if (n < HALF) begin : g_lo
                assign code[n] = ctl1_q[(HALF-1-n)*2 +: 2];
            end else begin : g_hi
                assign code[n] = ctl2_q[(HALF-1-(n-HALF))*2 +: 2];
            end
        end else begin : g_narrow
            assign code[n] = ctl1_q[DW-1-n] ? SNS_FALL : SNS_BOTH;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (word)
                WW'(IX_DIR): bus_rdata = flip(dir);
                WW'(IX_ODE): bus_rdata = flip(od);
                WW'(IX_DAT): bus_rdata = flip((lvl & ~dir) | (dat & dir));
                WW'(IX_EVT): bus_rdata = flip(evt);
                WW'(IX_MSK): bus_rdata = flip(msk);
                WW'(IX_CT1): bus_rdata = ctl1_q;
                WW'(IX_CT2): bus_rdata = ctl2_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter bit TWO_BIT = 1'b0,
    parameter int RO_PINS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pad_out,
    output logic [DW-1:0] pad_oe,
    output logic          irq
);

    logic [DW-1:0]      lvl;
    logic [DW-1:0]      lvl_d;
    logic [DW-1:0]      hit;
    logic [DW-1:0]      dir;
    logic [DW-1:0]      od;
    logic [DW-1:0]      dat;
    logic [DW-1:0]      evt;
    logic [DW-1:0]      msk;
    logic [DW-1:0][1:0] code;

    gpio_edge_sync #(.DW(DW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl),
        .lvl_d  (lvl_d)
    );

    gpio_edge_sense #(.DW(DW)) u_sense (
        .lvl   (lvl),
        .lvl_d (lvl_d),
        .code  (code),
        .hit   (hit)
    );

    gpio_edge_regs #(
        .DW      (DW),
        .AW      (AW),
        .TWO_BIT (TWO_BIT),
        .RO_PINS (RO_PINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl       (lvl),
        .hit       (hit),
        .dir       (dir),
        .od        (od),
        .dat       (dat),
        .evt       (evt),
        .msk       (msk),
        .code      (code)
    );

    // open-drain pins only ever pull low
    assign pad_out = dat;
    assign pad_oe  = dir & ~(od & dat);
    assign irq     = |(evt & msk);

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
    import gpio_edge_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter bit TWO_BIT = 1'b0,
    parameter int RO_PINS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] lvl,
    input logic [DW-1:0] lvl_d,
    input logic [DW-1:0] hit,
    input logic [DW-1:0] evt,
    input logic [DW-1:0] msk,
    input logic [DW-1:0] od,
    input logic [DW-1:0] pad_oe,
    input logic [DW-1:0] pad_out,
    input logic          irq
);

    localparam logic [AW-1:0] EVT_ADDR = AW'(4 * IX_EVT);

    logic [DW-1:0] wd_pin;
    logic          evt_wr;

    for (genvar i = 0; i < DW; i++) begin : g_flip
        assign wd_pin[i] = bus_wdata[DW-1-i];
    end

    assign evt_wr = bus_we && (bus_addr == EVT_ADDR);

    // R5
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> ((evt & $past(wd_pin) & ~$past(hit)) == '0));

    // R5
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_wr |=> (($past(evt) & ~evt) == '0));

    // R6
    evt_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt & ~$past(evt) & ~$past(lvl ^ lvl_d)) == '0));

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk == '0) |-> !irq);

    // R4
    od_no_drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & od & pad_out) == '0));

    if (TWO_BIT) begin : g_ro
        // R10
        ro_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[DW-1 -: RO_PINS] == '0));
    end

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
    .DW      (DW),
    .AW      (AW),
    .TWO_BIT (TWO_BIT),
    .RO_PINS (RO_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .lvl       (lvl),
    .lvl_d     (lvl_d),
    .hit       (hit),
    .evt       (evt),
    .msk       (msk),
    .od        (od),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] pins;
    logic [31:0] rdA, rdB, poA, poB, oeA, oeB;
    logic        irqA, irqB;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model, register bit order
    logic [31:0] m_dir, m_od, m_dat, m_msk, m_ic1, m_ic2, m_evtA, m_evtB;

    always #2 clk = ~clk;

    gpio_edge_ctrl #(.TWO_BIT(1'b0)) i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdA), .pin_in(pins), .pad_out(poA), .pad_oe(oeA), .irq(irqA));

    gpio_edge_ctrl #(.TWO_BIT(1'b1)) i_gpio_edge_ctrl_wide (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdB), .pin_in(pins), .pad_out(poB), .pad_oe(oeB), .irq(irqB));

    function automatic logic [31:0] rev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // narrow scheme (R8): control bit 1 = falling only, 0 = both
    function automatic logic [31:0] hit_a(input logic [31:0] o, input logic [31:0] n,
                                          input logic [31:0] ic);
        return (ic & (~n & o)) | (~ic & (o ^ n));
    endfunction

    // wide scheme (R9): 00 both, 01 rise, 10 fall, 11 none
    function automatic logic [31:0] hit_b(input logic [31:0] o, input logic [31:0] n,
                                          input logic [31:0] c1, input logic [31:0] c2);
        logic [31:0] h;
        h = '0;
        for (int p = 0; p < 32; p++) begin
            int b;
            logic [1:0] c;
            b = 31 - p;
            c = (p < 16) ? c1[(15-p)*2 +: 2] : c2[(15-(p-16))*2 +: 2];
            case (c)
                2'b00:   h[b] = o[b] ^ n[b];
                2'b01:   h[b] = n[b] & ~o[b];
                2'b10:   h[b] = ~n[b] & o[b];
                default: h[b] = 1'b0;
            endcase
        end
        return h;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        case (a)
            5'h00: m_dir = d;
            5'h04: m_od  = d;
            5'h08: m_dat = d;
            5'h0C: begin m_evtA &= ~d; m_evtB &= ~d; end
            5'h10: m_msk = d;
            5'h14: m_ic1 = d;
            5'h18: m_ic2 = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] va, output logic [31:0] vb);
        @(negedge clk);
        addr = a;
        #1;
        va = rdA; vb = rdB;
    endtask

    task automatic setpins(input logic [31:0] v);
        logic [31:0] o;
        o = rev(pins);
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
        m_evtA |= hit_a(o, rev(v), m_ic1);
        m_evtB |= hit_b(o, rev(v), m_ic1, m_ic2);
    endtask

    task automatic check_all();
        logic [31:0] a, b, lv, dirB;
        lv   = rev(pins);
        dirB = m_dir & 32'hFFFF_FFF0;
        rd(5'h00, a, b);
        chk(a == m_dir, "R3 dir word", a, m_dir);
        chk(b == dirB,  "R10 dir word wide", b, dirB);
        rd(5'h04, a, b);
        chk(a == m_od && b == m_od, "R4 open-drain word", a, m_od);
        rd(5'h08, a, b);
        chk(a == ((lv & ~m_dir) | (m_dat & m_dir)), "R11 data read", a,
            (lv & ~m_dir) | (m_dat & m_dir));
        chk(b == ((lv & ~dirB) | (m_dat & dirB)), "R11 data read wide", b,
            (lv & ~dirB) | (m_dat & dirB));
        rd(5'h0C, a, b);
        chk(a == m_evtA, "R5 event word", a, m_evtA);
        chk(b == m_evtB, "R9 event word wide", b, m_evtB);
        rd(5'h10, a, b);
        chk(a == m_msk && b == m_msk, "R7 mask word", a, m_msk);
        rd(5'h14, a, b);
        chk(a == m_ic1 && b == m_ic1, "R8 control A", a, m_ic1);
        rd(5'h18, a, b);
        chk(a == 32'h0, "R8 control B narrow", a, 32'h0);
        chk(b == m_ic2, "R9 control B wide", b, m_ic2);
        rd(5'h1C, a, b);
        chk(a == 32'h0 && b == 32'h0, "R2 unmapped", a, 32'h0);
        rd(5'h09, a, b);
        chk(a == 32'h0 && b == 32'h0, "R2 unaligned", a, 32'h0);
        chk(poA == rev(m_dat) && poB == rev(m_dat), "R3 pad_out", poA, rev(m_dat));
        chk(oeA == rev(m_dir & ~(m_od & m_dat)), "R4 pad_oe", oeA, rev(m_dir & ~(m_od & m_dat)));
        chk(oeB == rev(dirB & ~(m_od & m_dat)), "R4 pad_oe wide", oeB, rev(dirB & ~(m_od & m_dat)));
        chk(irqA == |(m_evtA & m_msk), "R7 irq", 32'(irqA), 32'(|(m_evtA & m_msk)));
        chk(irqB == |(m_evtB & m_msk), "R7 irq wide", 32'(irqB), 32'(|(m_evtB & m_msk)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'h0005_EED1));
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pins = '0;
        m_dir = '0; m_od = '0; m_dat = '0; m_msk = '0;
        m_ic1 = '0; m_ic2 = '0; m_evtA = '0; m_evtB = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 7; k++) begin
            rd(5'(4*k), a, b);
            chk(a == 0 && b == 0, "R1 register after reset", a | b, 32'h0);
        end
        chk(oeA == 0 && oeB == 0, "R1 pad_oe after reset", oeA | oeB, 32'h0);
        chk(!irqA && !irqB, "R1 irq after reset", 32'(irqA | irqB), 32'h0);
        check_all();

        // R2 / R3 pin 0 lives in bit 31
        wr(5'h00, 32'h8000_0000);
        wr(5'h08, 32'h8000_0000);
        chk(poA == 32'h1, "R2 pin0 pad_out", poA, 32'h1);
        chk(oeA == 32'h1, "R3 pin0 pad_oe", oeA, 32'h1);
        // R4 open drain releases on 1, pulls on 0
        wr(5'h04, 32'h8000_0000);
        #1 chk(oeA == 32'h0, "R4 released on 1", oeA, 32'h0);
        wr(5'h08, 32'h0);
        #1 chk(oeA == 32'h1, "R4 driven on 0", oeA, 32'h1);
        check_all();
        wr(5'h00, 0); wr(5'h04, 0);

        // R6 latency: pin 5 (bit 26) rising
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        @(negedge clk); pins = 32'h20; addr = 5'h08;
        @(negedge clk);
        chk(rdA[26] == 1'b0, "R6 level not yet synced", rdA, 32'h0);
        @(negedge clk);
        chk(rdA[26] == 1'b1, "R6 level after two clocks", rdA, 32'h0400_0000);
        chk(!irqA, "R6 no event after two clocks", 32'(irqA), 32'h0);
        @(negedge clk);
        chk(irqA && irqB, "R6 event on third clock", 32'(irqA & irqB), 32'h1);
        m_evtA |= 32'h0400_0000; m_evtB |= 32'h0400_0000;
        check_all();

        // R5 clear in the same cycle as a new falling edge on pin 5
        @(negedge clk); pins = 32'h0;
        @(negedge clk);
        @(negedge clk); addr = 5'h0C; wdata = 32'h0400_0000; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(5'h0C, a, b);
        chk(a[26] && b[26], "R5 edge wins over clear", a & b, 32'h0400_0000);
        wr(5'h0C, 32'h0);
        rd(5'h0C, a, b);
        chk(a[26] && b[26], "R5 write 0 keeps event", a & b, 32'h0400_0000);
        wr(5'h0C, 32'h0400_0000);
        rd(5'h0C, a, b);
        chk(a == 0 && b == 0, "R5 write 1 clears", a | b, 32'h0);

        // R8 falling-only for pin 7 (bit 24) in narrow scheme
        wr(5'h14, 32'h0100_0000);
        setpins(32'h80);
        rd(5'h0C, a, b);
        chk(a[24] == 1'b0, "R8 rise ignored when falling-only", a, m_evtA);
        chk(b[24] == 1'b1, "R9 pin7 both edges wide", b, m_evtB);
        setpins(32'h0);
        rd(5'h0C, a, b);
        chk(a[24] == 1'b1, "R8 fall seen when falling-only", a, m_evtA);
        check_all();
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h14, 32'h0);

        // R9 codes for pins 16..19: none, fall, rise, both
        wr(5'h18, 32'hE400_0000);
        setpins(32'h000F_0000);
        rd(5'h0C, a, b);
        chk(b == 32'h0000_3000, "R9 rising codes", b, 32'h0000_3000);
        chk(a == 32'h0000_F000, "R8 both edges narrow", a, 32'h0000_F000);
        setpins(32'h0);
        rd(5'h0C, a, b);
        chk(b == 32'h0000_7000, "R9 falling codes", b, 32'h0000_7000);
        check_all();

        // R10 pins 28..31 listen-only in wide scheme
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, a, b);
        chk(b == 32'hFFFF_FFF0, "R10 dir bits 3..0 stay 0", b, 32'hFFFF_FFF0);
        chk(oeB[31:28] == 4'h0, "R10 pad_oe 28..31 low", 32'(oeB[31:28]), 32'h0);
        chk(oeA == 32'hFFFF_FFFF, "R3 all pins drive narrow", oeA, 32'hFFFF_FFFF);
        check_all();

        // constrained random
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0)      wr(5'(4 * ($urandom % 7)), $urandom);
            else if (op == 1) setpins(pins ^ $urandom);
            else if (op == 2) setpins(pins ^ (32'h1 << ($urandom % 32)));
            else              wr(5'h0C, $urandom);
            check_all();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule